// File: doc/BRIEF.md
# Banked ROM Address Mapper

This block turns a bank-relative ROM address into a physical ROM address for a voice playback engine whose memory may be split into one, two or four equal banks. Each bank is laid out as a self-contained image: its own phrase control area at its low addresses, followed by its sample data, with room for up to 256 phrases. The playback engine therefore always generates addresses as if its bank started at zero. The mapper replaces the top address bits with the bank number.

The partition mode is taken from the two low bits of a power-up command byte, either of the two power-up opcodes. It is held until the next power-up command. The bank number comes from external select pins. The pins are sampled only on the cycle playback starts, and the sampled value is held for the rest of that playback.

One mode code is illegal. The mapper flags it and falls back to the widest split. A smaller device variant uses 18-bit addresses and a single select pin. It is chosen by parameters.

Top module: `banked_rom_map`

## Requirements
- R1: After reset the latched mode is 00, the captured bank is 0, `mode_err_o` is 0 and `phys_addr_o` equals `rel_addr_i`.
- R2: In mode 00 the whole memory is one area: `phys_addr_o` equals `rel_addr_i` whatever bank was captured.
- R3: In mode 01, with two select pins, memory splits into halves: `phys_addr_o` = {bank[0], `rel_addr_i`[AW-2:0]}. With AW=20, bank 0 covers 00000h–7FFFFh and bank 1 covers 80000h–FFFFFh.
- R4: In mode 10, with two select pins, memory splits into quarters: `phys_addr_o` = {bank[1], bank[0], `rel_addr_i`[AW-3:0]}. Bank 2 with relative address 0 gives 80000h.
- R5: Mode 11, with two select pins, raises `mode_err_o` and maps exactly as mode 10. Every other mode holds `mode_err_o` low.
- R6: The mode is loaded from `cmd_byte_i`[1:0] on a clock edge where `cmd_valid_i` is high and `cmd_byte_i`[7:5] is 000 (opcodes 0000xxxx and 0001xxxx). Any other byte, or no strobe, leaves the mode unchanged.
- R7: The bank is loaded from `sel_i` on a clock edge where `play_start_i` is high. Changes on `sel_i` at any other time do not affect `phys_addr_o`.
- R8: Relative address bits at or above the bank field are discarded. In mode 10, a relative address of FFFFFh with bank 0 maps to 3FFFFh.
- R9: With AW=18 and one select pin, mode 00 is flat and mode 10 splits memory into halves on bank[0]. Modes 01 and 11 raise `mode_err_o` and map as halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Strobe marking a first command byte |
| cmd_byte_i | input | 8 | Command byte; power-up opcodes carry the mode in bits 1:0 |
| play_start_i | input | 1 | High for the cycle playback begins; samples the select pins |
| sel_i | input | SEL_W | Bank select pins |
| rel_addr_i | input | AW | Bank-relative address |
| phys_addr_o | output | AW | Physical ROM address |
| mode_err_o | output | 1 | The latched mode code is prohibited |

## Verification
The embedded properties check three things on every cycle:
- the mode and the bank register stay unchanged unless their own load strobe is present;
- the bits below the bank field always pass through unchanged;
- in flat mode the address passes straight through, and in the prohibited mode the top bits carry the captured bank.

Only the directed scenarios can show the following:
- each split resolves to the exact physical address ranges;
- non-power-up opcodes are ignored;
- select-pin movement during playback never reaches the address;
- the single-pin variant decodes its modes correctly.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [1:0] {
    MODE_FLAT    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_BAD     = 2'b11
  } brm_mode_e;

  localparam logic [2:0] PUP_OPC_HI = 3'b000;

  // number of address bits taken over by the bank number
  function automatic int bank_bits(input logic [1:0] mode, input int sel_w);
    int nb;
    if (mode == MODE_FLAT) begin
      nb = 0;
    end else if (sel_w < 2) begin
      nb = 1;
    end else if (mode == MODE_HALF) begin
      nb = 1;
    end else begin
      nb = 2;
    end
    if (nb > sel_w) nb = sel_w;
    return nb;
  endfunction

  function automatic logic mode_illegal(input logic [1:0] mode, input int sel_w);
    if (sel_w < 2) return mode[0];
    return (mode == MODE_BAD);
  endfunction

endpackage

// File: rtl/brm_mode_latch.sv
module brm_mode_latch (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  output logic [1:0] mode_o
);
  import brm_pkg::*;

  logic is_pup;
  assign is_pup = cmd_valid_i && (cmd_byte_i[7:5] == PUP_OPC_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= MODE_FLAT;
    else if (is_pup) mode_o <= cmd_byte_i[1:0];
  end

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_byte_i[7:5] == 3'b000) |=> $stable(mode_o)); // R6

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_byte_i[7:5] == 3'b000) |=> mode_o == $past(cmd_byte_i[1:0])); // R6

endmodule

// File: rtl/brm_bank_capture.sv
module brm_bank_capture #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             play_start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] bank_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           bank_o <= '0;
    else if (play_start_i) bank_o <= sel_i;
  end

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_start_i |=> $stable(bank_o)); // R7

endmodule

// File: rtl/brm_addr_compose.sv
module brm_addr_compose #(
  parameter int AW    = 20,
  parameter int SEL_W = 2
) (
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] bank_i,
  input  logic [AW-1:0]    rel_i,
  output logic [AW-1:0]    phys_o,
  output logic             err_o
);
  import brm_pkg::*;

  int nb;

  always_comb begin
    nb     = bank_bits(mode_i, SEL_W);
    phys_o = rel_i;
    for (int k = 0; k < SEL_W; k++) begin
      if (k < nb) phys_o[AW - nb + k] = bank_i[k];
    end
    err_o = mode_illegal(mode_i, SEL_W);
  end

endmodule

// File: rtl/banked_rom_map.sv
module banked_rom_map #(
  parameter int AW    = 20,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_byte_i,
  input  logic             play_start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [AW-1:0]    rel_addr_i,
  output logic [AW-1:0]    phys_addr_o,
  output logic             mode_err_o
);

  localparam int LOW_W = AW - SEL_W;

  logic [1:0]       mode_q;
  logic [SEL_W-1:0] bank_q;

  brm_mode_latch u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_byte_i  (cmd_byte_i),
    .mode_o      (mode_q)
  );

  brm_bank_capture #(.SEL_W(SEL_W)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .play_start_i (play_start_i),
    .sel_i        (sel_i),
    .bank_o       (bank_q)
  );

  brm_addr_compose #(.AW(AW), .SEL_W(SEL_W)) u_comp (
    .mode_i (mode_q),
    .bank_i (bank_q),
    .rel_i  (rel_addr_i),
    .phys_o (phys_addr_o),
    .err_o  (mode_err_o)
  );

  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[LOW_W-1:0] == rel_addr_i[LOW_W-1:0]); // R8

  AST_FLAT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |-> (phys_addr_o == rel_addr_i && !mode_err_o)); // R2

  AST_ERR_WIDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> (phys_addr_o[AW-1 -: SEL_W] == bank_q)); // R5

endmodule

// File: tb/sim_banked_rom_map.sv
module sim_banked_rom_map;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = 8'h00;
  logic        play_start = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic [19:0] rel = 20'h0;
  logic [19:0] phys;
  logic        err;
  logic [17:0] phys_s;
  logic        err_s;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // model state, kept from the requirements
  logic [1:0] m_mode = 2'b00;
  logic [1:0] m_bank = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_rom_map u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .play_start_i(play_start), .sel_i(sel), .rel_addr_i(rel),
    .phys_addr_o(phys), .mode_err_o(err)
  );

  banked_rom_map #(.AW(18), .SEL_W(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .play_start_i(play_start), .sel_i(sel[0]), .rel_addr_i(rel[17:0]),
    .phys_addr_o(phys_s), .mode_err_o(err_s)
  );

  function automatic logic [19:0] exp_big(input logic [1:0] m, input logic [1:0] b,
                                          input logic [19:0] r);
    case (m)
      2'b00:   return r;
      2'b01:   return {b[0], r[18:0]};
      default: return {b, r[17:0]};
    endcase
  endfunction

  function automatic logic [17:0] exp_small(input logic [1:0] m, input logic b,
                                            input logic [17:0] r);
    if (m == 2'b00) return r;
    return {b, r[16:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    tick();
    @(negedge clk);
    cmd_valid = 1'b0;
    if (b[7:5] == 3'b000) m_mode = b[1:0];
  endtask

  task automatic start_play(input logic [1:0] s);
    @(negedge clk);
    sel = s;
    play_start = 1'b1;
    tick();
    @(negedge clk);
    play_start = 1'b0;
    m_bank = s;
  endtask

  task automatic probe(input string tag, input logic [19:0] r);
    @(negedge clk);
    rel = r;
    #1;
    check(tag, {12'h0, phys}, {12'h0, exp_big(m_mode, m_bank, r)});
    check({tag, "_err"}, {31'h0, err}, {31'h0, m_mode == 2'b11});
  endtask

  task automatic probe_small(input string tag, input logic [17:0] r);
    @(negedge clk);
    rel = {2'b00, r};
    #1;
    check(tag, {14'h0, phys_s}, {14'h0, exp_small(m_mode, m_bank[0], r)});
    check({tag, "_err"}, {31'h0, err_s}, {31'h0, m_mode[0]});
  endtask

  task automatic t_reset();
    probe("R1_reset_a", 20'hABCDE);
    probe("R1_reset_b", 20'hFFFFF);
  endtask

  task automatic t_flat();
    send_cmd(8'h00);
    start_play(2'b11);
    probe("R2_flat_sel3", 20'hC1234);
    probe("R2_flat_zero", 20'h00000);
  endtask

  task automatic t_half();
    send_cmd(8'h01);
    start_play(2'b00);
    probe("R3_half_b0", 20'h7FFFF);
    start_play(2'b01);
    probe("R3_half_b1_lo", 20'h00000);
    probe("R3_half_b1_hi", 20'h7FFFF);
    start_play(2'b10);
    probe("R3_half_sel1_ignored", 20'h12345);
  endtask

  task automatic t_quarter();
    send_cmd(8'h1E);
    for (int b = 0; b < 4; b++) begin
      start_play(b[1:0]);
      probe("R4_quarter_base", 20'h00000);
      probe("R4_quarter_top", 20'h3FFFF);
    end
    start_play(2'b00);
    probe("R8_mask_full", 20'hFFFFF);
    start_play(2'b01);
    probe("R8_mask_b1", 20'hC0010);
  endtask

  task automatic t_bad();
    send_cmd(8'h03);
    start_play(2'b10);
    probe("R5_bad_b2", 20'h01234);
    probe("R5_bad_top", 20'hFFFFF);
  endtask

  task automatic t_ignore();
    send_cmd(8'h02);
    send_cmd(8'h41);
    probe("R6_play_opcode_ignored", 20'hFFFFF);
    send_cmd(8'h23);
    probe("R6_pdwn_ignored", 20'hFFFFF);
    @(negedge clk);
    cmd_byte = 8'h01;
    tick();
    probe("R6_no_strobe", 20'hFFFFF);
  endtask

  task automatic t_sel_hold();
    send_cmd(8'h02);
    start_play(2'b01);
    @(negedge clk);
    sel = 2'b10;
    tick();
    tick();
    probe("R7_sel_change_held", 20'h00000);
    start_play(2'b11);
    probe("R7_recapture", 20'h00000);
  endtask

  task automatic t_small();
    send_cmd(8'h00);
    start_play(2'b01);
    probe_small("R9_small_flat", 18'h3FFFF);
    send_cmd(8'h02);
    probe_small("R9_small_half_b1", 18'h00000);
    start_play(2'b00);
    probe_small("R9_small_half_b0", 18'h3FFFF);
    send_cmd(8'h11);
    start_play(2'b01);
    probe_small("R9_small_err01", 18'h00005);
    send_cmd(8'h03);
    probe_small("R9_small_err11", 18'h20000);
  endtask

  initial begin : watchdog
    for (int i = 0; i < WD_CYCLES; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flat();
    t_half();
    t_quarter();
    t_bad();
    t_ignore();
    t_sel_hold();
    t_small();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule